// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This block walks a range of erase blocks in one logical unit of a NAND target and finds the blocks that left the factory marked defective. For each block it issues a page read through a simple request/response port. The read targets the first location of the spare area in the block's first page. When that marker is intact, it reads the same location in the block's last page. A block counts as defective when a marker reads as all zeros or when the read reports an error. The verdicts go into a one-bit-per-block bitmap. At the end the block gives a count of defective blocks and a one-cycle completion pulse.

The scan starts with a `start` pulse while the block is idle. The page data size, the log2 of pages per block, the log2 of blocks per unit, the block count, the bus width and the unit number are all sampled on that pulse. Row addresses and column offsets are formed internally. An external agent serves the reads and replies in order, one response per request. The bus timing of the flash itself is handled outside this block.

Top module: `nand_badblock_scan`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req_valid`, `err_sticky` and `bad_count` are all 0.
- R2: The request row holds the page index in its low `ppb_log2` bits and the block index shifted left by `ppb_log2`. The unit number sits above both, shifted left by `ppb_log2 + blk_log2`. The block count must not exceed 2^`blk_log2`.
- R3: Each block's first request reads page 0. A second request, if one is made, reads page 2^`ppb_log2`-1. Blocks are visited in ascending order starting at 0.
- R4: In 8-bit mode (`cfg_x16`=0) the request column equals `cfg_page_bytes`. In 16-bit mode it equals `cfg_page_bytes`/2.
- R5: In 8-bit mode a response is a zero marker when `rd_rsp_data[7:0]` is 00h, whatever the upper byte holds. In 16-bit mode it is a zero marker only when all 16 bits are 0000h.
- R6: When the first-page response already marks a block defective, no request is made for that block's last page.
- R7: A response with `rd_rsp_err`=1 marks its block defective and sets `err_sticky`. `err_sticky` stays set until the next accepted start.
- R8: Bitmap bit `b` is 1 when block `b` is defective and 0 when it is good. It can be read combinationally through `bm_rd_addr`/`bm_rd_bit`. An accepted start clears every bit.
- R9: `done` is high for exactly one cycle after the last block is decided. At that point `bad_count` equals the number of defective blocks in the scan.
- R10: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid with an unchanged row and column.
- R11: A block count of 0 produces `done` with no request issued and `bad_count` 0.
- R12: A `start` pulse while `busy` is high has no effect on the scan in progress or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (idle only) |
| cfg_page_bytes | input | COL_W | Data bytes per page |
| cfg_ppb_log2 | input | SH_W | log2 of pages per block |
| cfg_blk_log2 | input | SH_W | log2 of blocks per unit |
| cfg_blk_count | input | BLK_W+1 | Number of blocks to scan |
| cfg_x16 | input | 1 | 1 = 16-bit target |
| cfg_lun | input | LUN_W | Logical unit number |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_row | output | ROW_W | Row address of request |
| rd_req_col | output | COL_W | Column of request |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 16 | Marker read back |
| rd_rsp_err | input | 1 | Read failed |
| bm_rd_addr | input | BLK_W | Bitmap read index |
| bm_rd_bit | output | 1 | Bitmap bit at index |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_count | output | BLK_W+1 | Defective blocks found |
| err_sticky | output | 1 | A read error occurred |

## Verification
Errors in the block index or phase show up at once in the row of the next request. A wrong phase also changes the number of requests made for each block, which is visible within one response. A bad verdict is latched into the bitmap and the count when a block is decided, but it can only be seen after `done`. The bench therefore compares every bitmap bit and the count at the end of each scan. Stray state on restart would show as an unexpected request sequence from the first request onward.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int NBS_DATA_W = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2,
        S_DONE = 2'd3
    } scan_state_t;

    // Marker is zero: low byte only in 8-bit mode, full word in 16-bit mode.
    function automatic logic marker_zero(input logic [NBS_DATA_W-1:0] d,
                                         input logic wide);
        marker_zero = wide ? (d == '0) : (d[7:0] == 8'h00);
    endfunction

endpackage

// File: rtl/nbs_addr_gen.sv
module nbs_addr_gen #(
    parameter int ROW_W = 24,
    parameter int COL_W = 16,
    parameter int SH_W  = 5,
    parameter int BLK_W = 8,
    parameter int LUN_W = 3
) (
    input  logic [LUN_W-1:0] lun,
    input  logic [BLK_W-1:0] blk,
    input  logic             last_page,
    input  logic [SH_W-1:0]  ppb_log2,
    input  logic [SH_W-1:0]  blk_log2,
    input  logic [COL_W-1:0] page_bytes,
    input  logic             wide,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    logic [SH_W:0]      lun_shift;
    logic [ROW_W-1:0]   page_field;
    logic [ROW_W-1:0]   blk_field;
    logic [ROW_W-1:0]   lun_field;

    always_comb begin
        lun_shift  = {1'b0, ppb_log2} + {1'b0, blk_log2};
        page_field = last_page ? ((ROW_W'(1) << ppb_log2) - ROW_W'(1)) : '0;
        blk_field  = ROW_W'(blk) << ppb_log2;
        lun_field  = ROW_W'(lun) << lun_shift;
        row        = lun_field | blk_field | page_field;
        col        = wide ? (page_bytes >> 1) : page_bytes;
    end
endmodule

// File: rtl/nbs_marker_eval.sv
module nbs_marker_eval
    import nbs_pkg::*;
(
    input  logic [NBS_DATA_W-1:0] data,
    input  logic                  err,
    input  logic                  wide,
    output logic                  bad
);
    always_comb bad = err | marker_zero(data, wide);
endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             we,
    input  logic [BLK_W-1:0] waddr,
    input  logic             wbit,
    input  logic [BLK_W-1:0] raddr,
    output logic             rbit
);
    localparam int DEPTH = 1 << BLK_W;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[waddr] <= wbit;
        end
    end

    assign rbit = bits_q[raddr];
endmodule

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan
    import nbs_pkg::*;
#(
    parameter int ROW_W = 24,
    parameter int COL_W = 16,
    parameter int SH_W  = 5,
    parameter int BLK_W = 8,
    parameter int LUN_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [COL_W-1:0]      cfg_page_bytes,
    input  logic [SH_W-1:0]       cfg_ppb_log2,
    input  logic [SH_W-1:0]       cfg_blk_log2,
    input  logic [BLK_W:0]        cfg_blk_count,
    input  logic                  cfg_x16,
    input  logic [LUN_W-1:0]      cfg_lun,
    output logic                  rd_req_valid,
    input  logic                  rd_req_ready,
    output logic [ROW_W-1:0]      rd_req_row,
    output logic [COL_W-1:0]      rd_req_col,
    input  logic                  rd_rsp_valid,
    input  logic [NBS_DATA_W-1:0] rd_rsp_data,
    input  logic                  rd_rsp_err,
    input  logic [BLK_W-1:0]      bm_rd_addr,
    output logic                  bm_rd_bit,
    output logic                  busy,
    output logic                  done,
    output logic [BLK_W:0]        bad_count,
    output logic                  err_sticky
);
    localparam int CNT_W = BLK_W + 1;

    scan_state_t       state;
    logic [COL_W-1:0]  page_bytes_q;
    logic [SH_W-1:0]   ppb_q;
    logic [SH_W-1:0]   blkl_q;
    logic [CNT_W-1:0]  count_q;
    logic              wide_q;
    logic [LUN_W-1:0]  lun_q;
    logic [BLK_W-1:0]  blk_q;
    logic              last_q;

    logic              wait_rsp;
    logic              accept_start;
    logic              rsp_bad;
    logic              commit;
    logic              final_blk;
    logic [SH_W-1:0]   ppb_now;

    assign wait_rsp     = (state == S_WAIT);
    assign accept_start = start && (state == S_IDLE);
    assign rd_req_valid = (state == S_REQ);
    assign busy         = (state != S_IDLE);
    assign done         = (state == S_DONE);
    assign ppb_now      = ppb_q;
    assign commit       = wait_rsp && rd_rsp_valid && (rsp_bad || last_q);
    assign final_blk    = ({1'b0, blk_q} == (count_q - CNT_W'(1)));

    nbs_addr_gen #(
        .ROW_W(ROW_W), .COL_W(COL_W), .SH_W(SH_W), .BLK_W(BLK_W), .LUN_W(LUN_W)
    ) i_addr (
        .lun       (lun_q),
        .blk       (blk_q),
        .last_page (last_q),
        .ppb_log2  (ppb_q),
        .blk_log2  (blkl_q),
        .page_bytes(page_bytes_q),
        .wide      (wide_q),
        .row       (rd_req_row),
        .col       (rd_req_col)
    );

    nbs_marker_eval i_eval (
        .data(rd_rsp_data),
        .err (rd_rsp_err),
        .wide(wide_q),
        .bad (rsp_bad)
    );

    nbs_bitmap #(.BLK_W(BLK_W)) i_map (
        .clk  (clk),
        .rst  (rst),
        .clear(accept_start),
        .we   (commit),
        .waddr(blk_q),
        .wbit (rsp_bad),
        .raddr(bm_rd_addr),
        .rbit (bm_rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            page_bytes_q <= '0;
            ppb_q        <= '0;
            blkl_q       <= '0;
            count_q      <= '0;
            wide_q       <= 1'b0;
            lun_q        <= '0;
            blk_q        <= '0;
            last_q       <= 1'b0;
            bad_count    <= '0;
            err_sticky   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        page_bytes_q <= cfg_page_bytes;
                        ppb_q        <= cfg_ppb_log2;
                        blkl_q       <= cfg_blk_log2;
                        count_q      <= cfg_blk_count;
                        wide_q       <= cfg_x16;
                        lun_q        <= cfg_lun;
                        blk_q        <= '0;
                        last_q       <= 1'b0;
                        bad_count    <= '0;
                        err_sticky   <= 1'b0;
                        state        <= (cfg_blk_count == '0) ? S_DONE : S_REQ;
                    end
                end
                S_REQ: begin
                    if (rd_req_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (rd_rsp_err) err_sticky <= 1'b1;
                        if (commit) begin
                            bad_count <= bad_count + CNT_W'(rsp_bad);
                            last_q    <= 1'b0;
                            if (final_blk) begin
                                state <= S_DONE;
                            end else begin
                                blk_q <= blk_q + BLK_W'(1);
                                state <= S_REQ;
                            end
                        end else begin
                            last_q <= 1'b1;
                            state  <= S_REQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
    parameter int ROW_W = 24,
    parameter int COL_W = 16,
    parameter int SH_W  = 5,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [ROW_W-1:0] rd_req_row,
    input logic [COL_W-1:0] rd_req_col,
    input logic             rd_rsp_valid,
    input logic             rd_rsp_err,
    input logic             wait_rsp,
    input logic [SH_W-1:0]  ppb_now,
    input logic [CNT_W-1:0] bad_count,
    input logic             err_sticky
);
    logic [ROW_W-1:0] pmask;
    assign pmask = (ROW_W'(1) << ppb_now) - ROW_W'(1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req_valid);

    assert_page_field_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (((rd_req_row & pmask) == '0) || ((rd_req_row & pmask) == pmask)));

    assert_err_sets_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        wait_rsp && rd_rsp_valid && rd_rsp_err |=> err_sticky);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_row) && $stable(rd_req_col));

    assert_count_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !(wait_rsp && rd_rsp_valid) && !(start && !busy) |=> $stable(bad_count));
endmodule

bind nand_badblock_scan nbs_checker #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SH_W(SH_W), .CNT_W(BLK_W + 1)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_row  (rd_req_row),
    .rd_req_col  (rd_req_col),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_err  (rd_rsp_err),
    .wait_rsp    (wait_rsp),
    .ppb_now     (ppb_now),
    .bad_count   (bad_count),
    .err_sticky  (err_sticky)
);

// File: tb/test_nand_badblock_scan.sv
module test_nand_badblock_scan;
    localparam int ROW_W = 24;
    localparam int COL_W = 16;
    localparam int SH_W  = 5;
    localparam int BLK_W = 8;
    localparam int LUN_W = 3;
    localparam int NBLK  = 1 << BLK_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [COL_W-1:0]  cfg_page_bytes = '0;
    logic [SH_W-1:0]   cfg_ppb_log2 = '0;
    logic [SH_W-1:0]   cfg_blk_log2 = '0;
    logic [BLK_W:0]    cfg_blk_count = '0;
    logic              cfg_x16 = 1'b0;
    logic [LUN_W-1:0]  cfg_lun = '0;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b0;
    logic [ROW_W-1:0]  rd_req_row;
    logic [COL_W-1:0]  rd_req_col;
    logic              rd_rsp_valid = 1'b0;
    logic [15:0]       rd_rsp_data = '0;
    logic              rd_rsp_err = 1'b0;
    logic [BLK_W-1:0]  bm_rd_addr = '0;
    logic              bm_rd_bit;
    logic              busy;
    logic              done;
    logic [BLK_W:0]    bad_count;
    logic              err_sticky;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;

    // bench model of the flash markers
    logic [15:0] mk_first [NBLK];
    logic [15:0] mk_last  [NBLK];
    logic        er_first [NBLK];
    logic        er_last  [NBLK];

    // expected progress of the scan
    int unsigned exp_blk;
    logic        exp_last;
    int unsigned n_req;

    always #10 clk = ~clk;

    nand_badblock_scan #(
        .ROW_W(ROW_W), .COL_W(COL_W), .SH_W(SH_W), .BLK_W(BLK_W), .LUN_W(LUN_W)
    ) i_nand_badblock_scan (
        .clk(clk), .rst(rst), .start(start),
        .cfg_page_bytes(cfg_page_bytes), .cfg_ppb_log2(cfg_ppb_log2),
        .cfg_blk_log2(cfg_blk_log2), .cfg_blk_count(cfg_blk_count),
        .cfg_x16(cfg_x16), .cfg_lun(cfg_lun),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .bm_rd_addr(bm_rd_addr), .bm_rd_bit(bm_rd_bit),
        .busy(busy), .done(done), .bad_count(bad_count), .err_sticky(err_sticky)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_zero(input logic [15:0] d, input logic wide);
        return wide ? (d == 16'h0000) : (d[7:0] == 8'h00);
    endfunction

    function automatic bit first_bad(input int unsigned b);
        return er_first[b] || is_zero(mk_first[b], cfg_x16);
    endfunction

    function automatic bit blk_bad(input int unsigned b);
        return first_bad(b) || er_last[b] || is_zero(mk_last[b], cfg_x16);
    endfunction

    function automatic logic [ROW_W-1:0] exp_row(input int unsigned b, input logic last);
        logic [ROW_W-1:0] pg;
        pg = last ? ((ROW_W'(1) << cfg_ppb_log2) - ROW_W'(1)) : '0;
        return (ROW_W'(cfg_lun) << (cfg_ppb_log2 + cfg_blk_log2)) | (ROW_W'(b) << cfg_ppb_log2) | pg;
    endfunction

    // responder: serves requests in order and checks their addresses
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_valid && !rst) begin
                logic [ROW_W-1:0] r;
                logic [COL_W-1:0] c;
                logic             bad1;
                repeat ($urandom % 3) @(negedge clk);
                rd_req_ready = 1'b1;
                r = rd_req_row;
                c = rd_req_col;
                @(negedge clk);
                rd_req_ready = 1'b0;
                n_req++;
                check(r == exp_row(exp_blk, exp_last), "R2/R3 row", r, exp_row(exp_blk, exp_last));
                check(c == (cfg_x16 ? cfg_page_bytes >> 1 : cfg_page_bytes), "R4 column", c,
                      cfg_x16 ? cfg_page_bytes >> 1 : cfg_page_bytes);
                rd_rsp_data = exp_last ? mk_last[exp_blk] : mk_first[exp_blk];
                rd_rsp_err  = exp_last ? er_last[exp_blk] : er_first[exp_blk];
                bad1 = first_bad(exp_blk);
                if (!exp_last && !bad1) begin
                    exp_last = 1'b1;
                end else begin
                    exp_last = 1'b0;
                    exp_blk++;
                end
                repeat ($urandom % 3) @(negedge clk);
                rd_rsp_valid = 1'b1;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_err   = 1'b0;
            end
        end
    end

    task automatic fill_markers(input int unsigned cnt);
        for (int b = 0; b < NBLK; b++) begin
            int unsigned kind;
            kind = $urandom % 12;
            mk_first[b] = {8'($urandom), 8'($urandom) | 8'h01};
            mk_last[b]  = {8'($urandom), 8'($urandom) | 8'h01};
            er_first[b] = 1'b0;
            er_last[b]  = 1'b0;
            case (kind)
                6: mk_first[b] = 16'h0000;
                7: mk_last[b]  = 16'h0000;
                8: mk_first[b] = {8'($urandom) | 8'h01, 8'h00};
                9: mk_last[b]  = {8'($urandom) | 8'h01, 8'h00};
                10: er_first[b] = 1'b1;
                11: er_last[b]  = 1'b1;
                default: ;
            endcase
        end
        if (cnt == 0) return;
    endtask

    task automatic run_scan(input logic [COL_W-1:0] pb, input int unsigned ppb, input int unsigned bl,
                            input int unsigned cnt, input logic wide, input int unsigned lun,
                            input bit poke_start);
        int unsigned exp_req, exp_bad;
        bit exp_err;
        int unsigned cyc;
        @(negedge clk);
        cfg_page_bytes = pb;
        cfg_ppb_log2   = SH_W'(ppb);
        cfg_blk_log2   = SH_W'(bl);
        cfg_blk_count  = (BLK_W+1)'(cnt);
        cfg_x16        = wide;
        cfg_lun        = LUN_W'(lun);
        exp_blk = 0; exp_last = 1'b0; n_req = 0;
        exp_req = 0; exp_bad = 0; exp_err = 1'b0;
        for (int b = 0; b < int'(cnt); b++) begin
            exp_req += first_bad(b) ? 1 : 2;
            exp_bad += blk_bad(b) ? 1 : 0;
            if (er_first[b] || (!first_bad(b) && er_last[b])) exp_err = 1'b1;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (poke_start && cyc == 25) start = 1'b1;   // R12 start while busy
            if (poke_start && cyc == 26) start = 1'b0;
        end
        check(n_req == exp_req, "R6 request count", n_req, exp_req);
        check(bad_count == (BLK_W+1)'(exp_bad), "R9 bad_count", bad_count, exp_bad);
        check(err_sticky == exp_err, "R7 err_sticky", err_sticky, exp_err);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 done single pulse", done, 0);
        for (int b = 0; b < int'(cnt); b++) begin
            bm_rd_addr = BLK_W'(b);
            #1;
            check(bm_rd_bit == blk_bad(b), "R8/R5 bitmap bit", bm_rd_bit, blk_bad(b));
        end
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rd_req_valid && !err_sticky && bad_count == 0,
              "R1 reset state", {busy, done, rd_req_valid, err_sticky}, 0);

        // 8-bit target, start poked mid-scan
        fill_markers(40);
        mk_first[3] = 16'h5500;   // R5 low byte zero: bad in 8-bit mode
        run_scan(16'd2048, 3, 6, 40, 1'b0, 2, 1'b1);

        // 16-bit target, full bitmap, high byte set means good (R5)
        fill_markers(256);
        mk_first[0] = 16'h5500; mk_last[0] = 16'h00aa; er_first[0] = 0; er_last[0] = 0;
        run_scan(16'd4096, 6, 8, 256, 1'b1, 5, 1'b0);
        bm_rd_addr = 8'd0;
        #1;
        check(bm_rd_bit == 1'b0, "R5 x16 partial-zero word is good", bm_rd_bit, 0);

        // zero blocks (R11)
        run_scan(16'd512, 2, 2, 0, 1'b0, 1, 1'b0);
        check(bad_count == 0 && n_req == 0, "R11 empty scan", n_req, 0);

        // single-page blocks, one good block: both reads at page 0
        fill_markers(1);
        mk_first[0] = 16'h1234; mk_last[0] = 16'h4321; er_first[0] = 0; er_last[0] = 0;
        run_scan(16'd512, 0, 1, 1, 1'b0, 7, 1'b0);

        // error on first page of block 0 (R7), no second read (R6)
        fill_markers(4);
        er_first[0] = 1'b1; mk_first[0] = 16'hffff;
        run_scan(16'd8192, 7, 3, 4, 1'b1, 0, 1'b0);

        // randomized configurations
        for (int k = 0; k < 3; k++) begin
            int unsigned ppb, bl, cnt;
            ppb = $urandom % 8;
            bl  = 1 + $urandom % 8;
            cnt = 1 + $urandom % (1 << bl);
            fill_markers(cnt);
            run_scan(COL_W'(($urandom % 16 + 1) * 256), ppb, bl, cnt, 1'($urandom), $urandom % 8, 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule